// File: doc/BRIEF.md
# Stacked Flash Window Address Decoder

This block turns a flat memory-mapped read address into a device select for a controller that serves four serial flash devices. The devices sit in four address windows placed end to end above a programmable base address. Each window's length comes from a software-set size in kilobytes, so the boundaries are running sums of the sizes and not fixed decode points. A window whose size is zero takes up no address space, and its device can never be selected.

For every request the block registers a one-hot select, the byte offset inside the chosen device, and an out-of-range flag. It also remembers the last device it selected. It raises a reselect indication when a request lands on a different device, so that the controller knows to reprogram device-specific settings such as clock rate before it starts the flash transfer.

Top module: `csw_window_decoder`

## Requirements
- R1: Window k (k = 0..3, in the fixed order first, second, third, fourth) starts at base_addr plus the byte sizes of windows 0..k-1 and is as long as its own byte size. The byte size is the kilobyte field shifted left by 10. Size field k occupies win_size_kb[k*SIZE_W +: SIZE_W].
- R2: A request inside window k yields cs_onehot with only bit k set and range_err low.
- R3: A window whose size field is zero is never selected, and the address span it would have covered belongs to the next non-empty window.
- R4: A request below base_addr, or at or above base_addr plus the sum of all four byte sizes, yields range_err high and cs_onehot all zero.
- R5: dev_offset equals the request address minus the start of the matched window, and is zero when range_err is high.
- R6: Outputs are registered. out_valid and the result of a request appear on the clock edge after the one at which req_valid was sampled high. A cycle without a request gives out_valid, cs_onehot, range_err and reselect all zero.
- R7: reselect is high for an in-range request whose device differs from the last device selected. Out-of-range requests leave the remembered device unchanged and never raise reselect.
- R8: After reset all outputs are zero and the remembered device is "none", so the first in-range request always raises reselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Flat request byte address |
| base_addr | input | ADDR_W | Start of the first window |
| win_size_kb | input | NUM_DEV*SIZE_W | Window sizes in kilobytes, window k at bits k*SIZE_W |
| out_valid | output | 1 | Registered result valid |
| cs_onehot | output | NUM_DEV | One-hot device select |
| dev_offset | output | ADDR_W | Byte offset inside the selected device |
| range_err | output | 1 | Request matched no window |
| reselect | output | 1 | Selected device differs from the previous one |

## Verification
The bench builds the decoder with a 16-bit address and 4-bit kilobyte size fields. At that width the full address space is only 64 KB, so a strided sweep plus every window edge (start-1, start, end-1, end) covers the whole map for each size set. The configurations include distinct sizes from base zero, empty first and third windows with a raised base, four maximum-size windows that fill the space to its last byte, and an all-empty map. The reselect history is carried across all of them, through out-of-range requests and through a mid-run reset.

// File: rtl/csw_pkg.sv
package csw_pkg;
  // kilobyte-to-byte scaling of the window size fields
  localparam int CSW_KB_SHIFT = 10;

  // width needed to hold a device index plus the "none" code
  function automatic int csw_tag_width(input int n_dev);
    return $clog2(n_dev + 1);
  endfunction
endpackage

// File: rtl/csw_window_map.sv
module csw_window_map
  import csw_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int SIZE_W  = 12,
  parameter int SPAN_W  = 33
) (
  input  logic [NUM_DEV*SIZE_W-1:0]   win_size_kb,
  output logic [NUM_DEV:0][SPAN_W-1:0] edges
);
  // byte length of one window
  function automatic logic [SPAN_W-1:0] kb_bytes(input logic [SIZE_W-1:0] kb);
    logic [SPAN_W-1:0] wide;
    wide = SPAN_W'(kb);
    return wide << CSW_KB_SHIFT;
  endfunction

  assign edges[0] = '0;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_prefix
    assign edges[g+1] = edges[g] + kb_bytes(win_size_kb[g*SIZE_W +: SIZE_W]);
  end
endmodule

// File: rtl/csw_match.sv
module csw_match #(
  parameter int NUM_DEV = 4,
  parameter int SPAN_W  = 33,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 3
) (
  input  logic [SPAN_W-1:0]            rel_addr,
  input  logic                         below_base,
  input  logic [NUM_DEV:0][SPAN_W-1:0] edges,
  output logic [NUM_DEV-1:0]           hit_vec,
  output logic [TAG_W-1:0]             hit_tag,
  output logic [ADDR_W-1:0]            hit_offset,
  output logic                         miss
);
  function automatic logic in_window(input logic [SPAN_W-1:0] a,
                                     input logic [SPAN_W-1:0] lo,
                                     input logic [SPAN_W-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  function automatic logic [TAG_W-1:0] onehot_tag(input logic [NUM_DEV-1:0] oh);
    logic [TAG_W-1:0] t;
    t = TAG_W'(NUM_DEV);
    for (int i = 0; i < NUM_DEV; i++)
      if (oh[i]) t = TAG_W'(i);
    return t;
  endfunction

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_win
    assign hit_vec[g] = !below_base && in_window(rel_addr, edges[g], edges[g+1]);
  end

  always_comb begin
    hit_offset = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (hit_vec[i]) hit_offset = ADDR_W'(rel_addr - edges[i]);
  end

  assign hit_tag = onehot_tag(hit_vec);
  assign miss    = (hit_vec == '0);
endmodule

// File: rtl/csw_track.sv
module csw_track #(
  parameter int NUM_DEV = 4,
  parameter int TAG_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [TAG_W-1:0] new_tag,
  output logic             changed
);
  localparam logic [TAG_W-1:0] TAG_NONE = TAG_W'(NUM_DEV);

  logic [TAG_W-1:0] last_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_tag <= TAG_NONE;
    else if (upd) last_tag <= new_tag;
  end

  assign changed = (last_tag != new_tag);
endmodule

// File: rtl/csw_window_decoder.sv
module csw_window_decoder
  import csw_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [ADDR_W-1:0]         base_addr,
  input  logic [NUM_DEV*SIZE_W-1:0] win_size_kb,
  output logic                      out_valid,
  output logic [NUM_DEV-1:0]        cs_onehot,
  output logic [ADDR_W-1:0]         dev_offset,
  output logic                      range_err,
  output logic                      reselect
);
  localparam int MAP_W  = SIZE_W + CSW_KB_SHIFT + 2;
  localparam int SPAN_W = ((ADDR_W > MAP_W) ? ADDR_W : MAP_W) + 1;
  localparam int TAG_W  = csw_tag_width(NUM_DEV);

  // named internal events
  logic [NUM_DEV:0][SPAN_W-1:0] edges;
  logic [SPAN_W-1:0]            rel_addr;
  logic                         below_base;
  logic [NUM_DEV-1:0]           hit_vec;
  logic [TAG_W-1:0]             hit_tag;
  logic [ADDR_W-1:0]            hit_offset;
  logic                         miss;
  logic                         dev_changed;
  logic                         track_upd;

  assign below_base = req_addr < base_addr;
  assign rel_addr   = SPAN_W'(req_addr) - SPAN_W'(base_addr);
  assign track_upd  = req_valid && !miss;

  csw_window_map #(
    .NUM_DEV(NUM_DEV), .SIZE_W(SIZE_W), .SPAN_W(SPAN_W)
  ) u_map (
    .win_size_kb(win_size_kb),
    .edges      (edges)
  );

  csw_match #(
    .NUM_DEV(NUM_DEV), .SPAN_W(SPAN_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)
  ) u_match (
    .rel_addr  (rel_addr),
    .below_base(below_base),
    .edges     (edges),
    .hit_vec   (hit_vec),
    .hit_tag   (hit_tag),
    .hit_offset(hit_offset),
    .miss      (miss)
  );

  csw_track #(
    .NUM_DEV(NUM_DEV), .TAG_W(TAG_W)
  ) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (track_upd),
    .new_tag(hit_tag),
    .changed(dev_changed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      cs_onehot  <= '0;
      dev_offset <= '0;
      range_err  <= 1'b0;
      reselect   <= 1'b0;
    end else begin
      out_valid  <= req_valid;
      cs_onehot  <= req_valid ? hit_vec : '0;
      dev_offset <= req_valid ? hit_offset : '0;
      range_err  <= req_valid && miss;
      reselect   <= track_upd && dev_changed;
    end
  end
endmodule

// File: rtl/csw_window_decoder_chk.sv
module csw_window_decoder_chk #(
  parameter int NUM_DEV = 4,
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic [NUM_DEV*SIZE_W-1:0] win_size_kb,
  input logic                      out_valid,
  input logic [NUM_DEV-1:0]        cs_onehot,
  input logic [ADDR_W-1:0]         dev_offset,
  input logic                      range_err,
  input logic                      reselect
);
  // R2
  single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !range_err) |-> ($countones(cs_onehot) == 1));

  // R4
  err_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (cs_onehot == '0));

  // R5
  err_offset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (dev_offset == '0));

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (cs_onehot == '0 && !range_err && !reselect));

  // R7
  reselect_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reselect |-> (out_valid && !range_err));

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_zero
    // R3
    zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_size_kb[g*SIZE_W +: SIZE_W] == '0) |=> !cs_onehot[g]);
  end
endmodule

bind csw_window_decoder csw_window_decoder_chk #(
  .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .win_size_kb(win_size_kb),
  .out_valid  (out_valid),
  .cs_onehot  (cs_onehot),
  .dev_offset (dev_offset),
  .range_err  (range_err),
  .reselect   (reselect)
);

// File: tb/csw_window_decoder_bench.sv
module csw_window_decoder_bench;
  localparam int AW = 16;
  localparam int SW = 4;
  localparam int ND = 4;
  localparam int SPACE = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [AW-1:0]    base_addr = '0;
  logic [ND*SW-1:0] win_size_kb = '0;
  logic             out_valid;
  logic [ND-1:0]    cs_onehot;
  logic [AW-1:0]    dev_offset;
  logic             range_err;
  logic             reselect;

  int checks = 0;
  int errors = 0;
  int exp_last = ND;
  bit done = 0;

  always #5 clk = ~clk;

  csw_window_decoder #(.NUM_DEV(ND), .ADDR_W(AW), .SIZE_W(SW)) u_csw_window_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .base_addr(base_addr), .win_size_kb(win_size_kb), .out_valid(out_valid),
    .cs_onehot(cs_onehot), .dev_offset(dev_offset), .range_err(range_err),
    .reselect(reselect)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int size_of(input int k);
    return int'(win_size_kb[k*SW +: SW]) * 1024;
  endfunction

  // reference decode: returns device index or -1, and byte offset
  function automatic void ref_decode(input int a, output int dev, output int off);
    int lo;
    dev = -1;
    off = 0;
    lo = int'(base_addr);
    if (a < lo) return;
    for (int k = 0; k < ND; k++) begin
      if (a >= lo && a < lo + size_of(k)) begin
        dev = k;
        off = a - lo;
      end
      lo = lo + size_of(k);
    end
  endfunction

  task automatic apply(input int a);
    int dev, off, exp_resel;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(a);
    ref_decode(a, dev, off);
    exp_resel = 0;
    if (dev >= 0) begin
      exp_resel = (dev != exp_last) ? 1 : 0;
      exp_last  = dev;
    end
    @(posedge clk);
    #1;
    chk("R6", "out_valid", out_valid, 1);
    if (dev < 0) begin
      chk("R4", "range_err", range_err, 1);
      chk("R4", "cs_onehot", cs_onehot, 0);
      chk("R5", "offset on error", dev_offset, 0);
    end else begin
      chk("R2", "cs_onehot", cs_onehot, longint'(1) << dev);
      chk("R2", "range_err", range_err, 0);
      chk("R5", "dev_offset", dev_offset, off);
    end
    chk("R7", "reselect", reselect, exp_resel);
    for (int k = 0; k < ND; k++)
      if (size_of(k) == 0) chk("R3", "empty window select", cs_onehot[k], 0);
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    chk("R6", "idle out_valid", out_valid, 0);
    chk("R6", "idle cs_onehot", cs_onehot, 0);
    chk("R6", "idle range_err", range_err, 0);
    chk("R6", "idle reselect", reselect, 0);
  endtask

  task automatic run_config(input int base, input int s0, input int s1, input int s2, input int s3);
    int lo, hi;
    @(negedge clk);
    base_addr   = AW'(base);
    win_size_kb = {SW'(s3), SW'(s2), SW'(s1), SW'(s0)};
    for (int a = 0; a < SPACE; a += 97) apply(a);
    lo = base;
    for (int k = 0; k < ND; k++) begin
      hi = lo + size_of(k);
      if (lo - 1 >= 0) apply(lo - 1);
      if (lo < SPACE) begin
        apply(lo);
        // R1: the first byte of a non-empty window selects that window at offset zero
        if (hi > lo) begin
          chk("R1", "window start select", cs_onehot, longint'(1) << k);
          chk("R1", "window start offset", dev_offset, 0);
        end
      end
      if (hi - 1 >= 0 && hi - 1 < SPACE) apply(hi - 1);
      if (hi < SPACE) apply(hi);
      lo = hi;
    end
    idle_check();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "reset out_valid", out_valid, 0);
    chk("R8", "reset cs_onehot", cs_onehot, 0);
    chk("R8", "reset range_err", range_err, 0);
    chk("R8", "reset reselect", reselect, 0);
    @(negedge clk);
    rst_n = 1'b1;
    base_addr   = '0;
    win_size_kb = {SW'(4), SW'(3), SW'(2), SW'(1)};

    // R8: first in-range request after reset reselects
    apply(16);
    chk("R8", "first hit reselect", reselect, 1);

    // R7: an error between two hits on the same device does not disturb the memory
    apply(20);
    chk("R7", "same device no reselect", reselect, 0);
    apply(60000);
    chk("R7", "error no reselect", reselect, 0);
    apply(24);
    chk("R7", "same device after error", reselect, 0);
    apply(1024);
    chk("R7", "new device reselect", reselect, 1);

    run_config(0, 1, 2, 3, 4);
    run_config(16'h1000, 0, 4, 0, 2);
    run_config(16'h1000, 15, 15, 15, 15);
    run_config(0, 0, 0, 0, 0);
    run_config(16'h0400, 2, 0, 7, 0);

    // R8: a reset in mid-run forgets the last device
    @(negedge clk);
    base_addr   = '0;
    win_size_kb = {SW'(1), SW'(1), SW'(1), SW'(1)};
    apply(5);
    apply(6);
    chk("R7", "repeat device no reselect", reselect, 0);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_last = ND;
    apply(7);
    chk("R8", "reselect after reset", reselect, 1);
    idle_check();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule